// File: doc/BRIEF.md
# Assignable Shared Divide Counter

This block holds one 8-bit divide counter that two consumers share: a general-purpose timer, which uses it ahead of its count register, and a watchdog, which uses it behind its time-out oscillator. A single owner bit hands the counter to exactly one of them. A 3-bit ratio code sets how many input ticks make one output tick. The owner sees its tick stream divided, and the other consumer sees its own input tick unchanged.

The counter advances only on the owner's input tick. Two clear strobes can reset it. One comes from a write to the timer count register and the other from a watchdog-clear command, and the block honours only the strobe that belongs to the current owner. Software can neither read nor write the counter. Its only visible state is a phase output, which is the counter bit that sets the division period. That bit is a square wave with equal high and low times.

Top module: `pscl_share_top`

## Requirements
- R1: After reset the counter is zero. `phase_o` is 0, and the owner's first output tick comes on exactly the N-th owner input tick, where N is the selected division.
- R2: With `own_wdt_i` = 0 (timer owns the counter), ratio code k (0..7) divides `tmr_src_i` by 2^(k+1). `tmr_tick_o` pulses for one cycle on the input tick that wraps the low k+1 counter bits from all ones.
- R3: With `own_wdt_i` = 1 (watchdog owns the counter), ratio code k divides `wdt_src_i` by 2^k. Code 0 passes every watchdog input tick through.
- R4: The consumer that does not own the counter gets its raw input tick unchanged in the same cycle.
- R5: With the timer as owner, `tmr_wr_clr_i` sets the counter to zero at the next edge.
- R6: With the watchdog as owner, `tmr_wr_clr_i` has no effect on the counter.
- R7: With the watchdog as owner, `wdt_clr_i` sets the counter to zero at the next edge.
- R8: With the timer as owner, `wdt_clr_i` has no effect on the counter.
- R9: An owner clear and an owner input tick in the same cycle give no divided output tick, and the counter ends at zero.
- R10: `phase_o` is counter bit k for the timer owner and bit k-1 for the watchdog owner, or 0 when the watchdog owns the counter with code 0. It is therefore high for half of each division period.
- R11: The counter holds its value in any cycle that has no owner input tick and no owner clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_wdt_i | input | 1 | Owner select: 0 timer, 1 watchdog |
| ratio_i | input | 3 | Division ratio code |
| tmr_src_i | input | 1 | Timer input tick |
| wdt_src_i | input | 1 | Watchdog input tick |
| tmr_wr_clr_i | input | 1 | Timer count register write strobe |
| wdt_clr_i | input | 1 | Watchdog-clear command strobe |
| tmr_tick_o | output | 1 | Tick to the timer count register |
| wdt_tick_o | output | 1 | Tick to the watchdog |
| phase_o | output | 1 | Counter bit that sets the division period |

## Verification
The case that needs care is an owner clear that lands in the same cycle as an owner input tick. Counting and clearing then act on one register in one edge, and the divided tick must not escape. The random phase drives clears and ticks independently at high rates so that such collisions happen often under both owners and all ratio codes. A directed case places a clear on the exact tick that would wrap the counter. Each collision is judged by the missing output pulse in that cycle and by `phase_o` together with the timing of the next output tick, both compared against a bench model of the counter.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
   typedef enum logic {
      OWNER_TMR = 1'b0,
      OWNER_WDT = 1'b1
   } owner_e;

   // mask of n low ones, n up to 32
   function automatic logic [31:0] low_ones(input int unsigned n);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < int'(n)) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pscl_counter.sv
module pscl_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pscl_tap.sv
module pscl_tap #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] ratio,
   output logic             tmr_wrap,
   output logic             wdt_wrap,
   output logic             tmr_phase,
   output logic             wdt_phase
);
   localparam int NUM_TAPS = 2 ** SEL_W;

   logic [NUM_TAPS-1:0] full_run;
   logic [NUM_TAPS-1:0] tap_bit;
   logic [SEL_W-1:0]    ratio_m1;
   logic                ratio_zero;

   // full_run[k]: low k+1 counter bits are all ones
   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      assign full_run[k] = &cnt[k:0];
      assign tap_bit[k]  = cnt[k];
   end

   assign ratio_zero = (ratio == '0);
   assign ratio_m1   = ratio - {{(SEL_W-1){1'b0}}, 1'b1};

   always_comb begin
      tmr_wrap  = full_run[ratio];
      tmr_phase = tap_bit[ratio];
      if (ratio_zero) begin
         wdt_wrap  = 1'b1;
         wdt_phase = 1'b0;
      end else begin
         wdt_wrap  = full_run[ratio_m1];
         wdt_phase = tap_bit[ratio_m1];
      end
   end
endmodule

// File: rtl/pscl_route.sv
module pscl_route
   import pscl_pkg::*;
(
   input  owner_e owner,
   input  logic   tmr_src,
   input  logic   wdt_src,
   input  logic   tmr_wr_clr,
   input  logic   wdt_clr,
   input  logic   tmr_wrap,
   input  logic   wdt_wrap,
   input  logic   tmr_phase,
   input  logic   wdt_phase,
   output logic   cnt_inc,
   output logic   cnt_clr,
   output logic   tmr_tick,
   output logic   wdt_tick,
   output logic   phase
);
   always_comb begin
      cnt_inc  = 1'b0;
      cnt_clr  = 1'b0;
      tmr_tick = tmr_src;
      wdt_tick = wdt_src;
      phase    = 1'b0;
      unique case (owner)
         OWNER_TMR: begin
            cnt_clr  = tmr_wr_clr;
            cnt_inc  = tmr_src;
            tmr_tick = tmr_src & tmr_wrap & ~tmr_wr_clr;
            phase    = tmr_phase;
         end
         OWNER_WDT: begin
            cnt_clr  = wdt_clr;
            cnt_inc  = wdt_src;
            wdt_tick = wdt_src & wdt_wrap & ~wdt_clr;
            phase    = wdt_phase;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pscl_share_top.sv
module pscl_share_top
   import pscl_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_wdt_i,
   input  logic [SEL_W-1:0] ratio_i,
   input  logic             tmr_src_i,
   input  logic             wdt_src_i,
   input  logic             tmr_wr_clr_i,
   input  logic             wdt_clr_i,
   output logic             tmr_tick_o,
   output logic             wdt_tick_o,
   output logic             phase_o
);
   localparam int NUM_TAPS = 2 ** SEL_W;

   if (SEL_W < 1) begin : g_bad_sel
      $error("pscl_share_top: SEL_W must be at least 1");
   end
   if (CNT_W < NUM_TAPS) begin : g_bad_width
      $error("pscl_share_top: CNT_W must cover every ratio tap");
   end

   owner_e           owner;
   logic [CNT_W-1:0] cnt;
   logic             cnt_inc, cnt_clr;
   logic             tmr_wrap, wdt_wrap, tmr_phase, wdt_phase;

   assign owner = own_wdt_i ? OWNER_WDT : OWNER_TMR;

   pscl_counter #(.CNT_W(CNT_W)) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .cnt   (cnt)
   );

   pscl_tap #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_tap (
      .cnt       (cnt),
      .ratio     (ratio_i),
      .tmr_wrap  (tmr_wrap),
      .wdt_wrap  (wdt_wrap),
      .tmr_phase (tmr_phase),
      .wdt_phase (wdt_phase)
   );

   pscl_route i_route (
      .owner      (owner),
      .tmr_src    (tmr_src_i),
      .wdt_src    (wdt_src_i),
      .tmr_wr_clr (tmr_wr_clr_i),
      .wdt_clr    (wdt_clr_i),
      .tmr_wrap   (tmr_wrap),
      .wdt_wrap   (wdt_wrap),
      .tmr_phase  (tmr_phase),
      .wdt_phase  (wdt_phase),
      .cnt_inc    (cnt_inc),
      .cnt_clr    (cnt_clr),
      .tmr_tick   (tmr_tick_o),
      .wdt_tick   (wdt_tick_o),
      .phase      (phase_o)
   );
endmodule

// File: rtl/pscl_share_chk.sv
module pscl_share_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             own_wdt_i,
   input logic [SEL_W-1:0] ratio_i,
   input logic             tmr_src_i,
   input logic             wdt_src_i,
   input logic             tmr_wr_clr_i,
   input logic             wdt_clr_i,
   input logic             tmr_tick_o,
   input logic             wdt_tick_o,
   input logic             phase_o
);
   assert_tmr_tick_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_tick_o |-> tmr_src_i);
   assert_wdt_tick_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_tick_o |-> wdt_src_i);
   assert_raw_wdt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !own_wdt_i |-> (wdt_tick_o == wdt_src_i));
   assert_raw_tmr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      own_wdt_i |-> (tmr_tick_o == tmr_src_i));
   assert_tmr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_wdt_i && tmr_wr_clr_i) |=> !phase_o);
   assert_wdt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wdt_i && wdt_clr_i) |=> !phase_o);
   assert_clear_blocks_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((!own_wdt_i && tmr_wr_clr_i) |-> !tmr_tick_o) and
      ((own_wdt_i && wdt_clr_i) |-> !wdt_tick_o));
   assert_tmr_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wdt_i && !wdt_clr_i && !wdt_src_i) |=>
      (!$stable(ratio_i) || !$stable(own_wdt_i) || $stable(phase_o)));
   assert_wdt_clear_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_wdt_i && !tmr_wr_clr_i && !tmr_src_i) |=>
      (!$stable(ratio_i) || !$stable(own_wdt_i) || $stable(phase_o)));
   assert_wdt_code0_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (own_wdt_i && ratio_i == '0) |-> !phase_o);
endmodule

bind pscl_share_top pscl_share_chk #(.SEL_W(SEL_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .own_wdt_i    (own_wdt_i),
   .ratio_i      (ratio_i),
   .tmr_src_i    (tmr_src_i),
   .wdt_src_i    (wdt_src_i),
   .tmr_wr_clr_i (tmr_wr_clr_i),
   .wdt_clr_i    (wdt_clr_i),
   .tmr_tick_o   (tmr_tick_o),
   .wdt_tick_o   (wdt_tick_o),
   .phase_o      (phase_o)
);

// File: tb/test_pscl_share_top.sv
module test_pscl_share_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       own_wdt = 1'b0;
   logic [2:0] ratio = 3'd0;
   logic       tsrc = 1'b0, wsrc = 1'b0, twr = 1'b0, wclr = 1'b0;
   logic       ttick, wtick, phase;

   int         checks = 0;
   int         errors = 0;
   logic [7:0] model = 8'd0;
   string      tag = "";

   always #10 clk = ~clk;

   pscl_share_top i_pscl_share_top (
      .clk(clk), .rst_n(rst_n), .own_wdt_i(own_wdt), .ratio_i(ratio),
      .tmr_src_i(tsrc), .wdt_src_i(wsrc), .tmr_wr_clr_i(twr), .wdt_clr_i(wclr),
      .tmr_tick_o(ttick), .wdt_tick_o(wtick), .phase_o(phase)
   );

   function automatic logic wraps(input logic [7:0] m, input int n);
      logic [7:0] mk;
      mk = 8'((1 << n) - 1);
      return (m & mk) == mk;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b (ratio=%0d own_wdt=%0b)",
                  req, act, exp, ratio, own_wdt);
      end
   endtask

   task automatic step(input logic a, input logic [2:0] r, input logic ti,
                       input logic wi, input logic tc, input logic wc);
      logic clr_act, e_t, e_w, e_p;
      string rt, rw, rp;
      @(negedge clk);
      own_wdt = a; ratio = r; tsrc = ti; wsrc = wi; twr = tc; wclr = wc;
      #2;
      clr_act = a ? wc : tc;
      e_t = ti; e_w = wi;
      if (!a) begin
         e_t = ti && wraps(model, int'(r) + 1) && !clr_act;
         e_p = model[r];
         rt = clr_act ? "R9" : "R2"; rw = "R4";
      end else begin
         e_w = wi && wraps(model, int'(r)) && !clr_act;
         e_p = (r == 3'd0) ? 1'b0 : model[r - 3'd1];
         rw = clr_act ? "R9" : "R3"; rt = "R4";
      end
      rp = "R10";
      if (tag != "") begin rt = tag; rw = tag; rp = tag; end
      check(rt, ttick, e_t);
      check(rw, wtick, e_w);
      check(rp, phase, e_p);
      if (clr_act) model = 8'd0;
      else if (a ? wi : ti) model = model + 8'd1;
   endtask

   initial begin
      #200000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      #1;
      checks++;
      if (phase !== 1'b0) begin
         errors++;
         $display("FAIL R1: actual=%0b expected=0", phase);
      end
      #40;
      @(negedge clk);
      rst_n = 1'b1;

      // R1: first divided tick after exactly 4 ticks at code 1 (timer)
      tag = "R1";
      for (int i = 0; i < 5; i++) step(1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      tag = "";
      step(1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);

      // R11: idle cycles with no owner tick keep phase
      tag = "R11";
      step(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);

      // R8: watchdog clear ignored under timer ownership
      tag = "R8";
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R3: watchdog code 0 passes every tick
      tag = "R3";
      step(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);

      // R6: timer write ignored under watchdog ownership
      tag = "R6";
      step(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
      step(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);

      // R7 and R9: watchdog clear on the wrapping tick
      tag = "R9";
      step(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1);
      tag = "R7";
      for (int i = 0; i < 4; i++) step(1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);

      // R5: timer write clears under timer ownership
      tag = "R5";
      step(1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) step(1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);

      // R2: full ratio 7 run of 256 timer ticks
      tag = "R2";
      step(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 260; i++) step(1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0);
      tag = "";

      // random mix, clears colliding with ticks (R9, R10)
      begin
         logic a;
         logic [2:0] r;
         a = 1'b0; r = 3'd0;
         for (int i = 0; i < 6000; i++) begin
            if (($urandom % 40) == 0) a = ~a;
            if (($urandom % 30) == 0) r = 3'($urandom % 8);
            step(a, r, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 ($urandom % 12) == 0, ($urandom % 12) == 0);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule